// File: doc/BRIEF.md
# Two-Level Program Counter Sequencer

This block holds the program-counter state of a simple in-order core and moves it forward once for each retired operation. It runs two counters, one nested inside the other. The architectural PC walks through instructions. A micro PC walks through the micro ops of an instruction that the decoder expands into several steps. While a multi-step instruction is in progress, the architectural PC stays where it is and only the micro PC moves. When the last micro op retires, the micro counter returns to its idle values and the PC moves on.

The PC chain is built in one of two forms, chosen by a parameter:
- **Plain:** a current/next pair.
- **Delay slot:** a three-stage current/next/next-next chain.

A fault strobe overrides normal sequencing. It loads the PC from a vector input, restarts the chain after that vector, and abandons any macro op in progress. The state changes only on cycles where the advance strobe is high. All outputs are registered.

Top module: `pc_sequencer`

## Requirements
- R1: After a synchronous reset, `pc_o` equals the `RESET_VEC` parameter (default 0x1000), `upc_o` is 0, and `in_macro_o` is 0.
- R2: On a clock edge with `adv_i` low, `pc_o`, `upc_o` and `in_macro_o` keep their values, whatever the other inputs are.
- R3: An advance with no fault, no macro op in progress and `is_macro_i` low adds `INSN_BYTES` (default 4) to `pc_o`. `upc_o` stays 0. In delay-slot mode the PC takes the next PC, and the next PC takes the next-next PC.
- R4: An advance with no macro op in progress, `is_macro_i` high and `last_uop_i` low has four effects:
  - micro op index 0 retires;
  - `in_macro_o` goes to 1;
  - `upc_o` becomes 1;
  - `pc_o` holds.
- R5: While `in_macro_o` is 1, an advance with `last_uop_i` low has three effects:
  - `upc_o` increments by 1 (it loads the next micro PC, and the next micro PC increments);
  - `pc_o` holds;
  - `is_macro_i` is ignored.
- R6: While `in_macro_o` is 1, an advance with `last_uop_i` high does three things:
  - clears `in_macro_o`;
  - returns `upc_o` to 0, with the next micro PC at 1;
  - adds `INSN_BYTES` to `pc_o`.
- R7: A macro op whose micro op 0 is also its last (`is_macro_i` and `last_uop_i` both high, outside a macro op) retires in one advance. `pc_o` adds `INSN_BYTES`, and `in_macro_o` stays 0.
- R8: Outside a macro op, with `is_macro_i` low, `last_uop_i` has no effect on the result of an advance.
- R9: An advance with `fault_i` high has priority over every other input. It loads `pc_o` from `fault_vec_i`, clears `in_macro_o`, and sets `upc_o` to 0.
- R10: After a fault, plain advances continue sequentially from the fault vector in steps of `INSN_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Retire strobe; state changes only when high |
| is_macro_i | input | 1 | The decoded instruction expands into micro ops |
| last_uop_i | input | 1 | The current micro op is the final one |
| fault_i | input | 1 | Redirect to the fault vector |
| fault_vec_i | input | AW | Handler address loaded on a fault |
| pc_o | output | AW | Current architectural PC |
| upc_o | output | UW | Current micro PC |
| in_macro_o | output | 1 | A macro op is in progress |

## Verification
Every result of this block comes from one register. So the PC, micro PC and macro flag due for an advance appear on the clock edge that samples that advance, and do not change before the next edge. The driver applies inputs at a falling edge. Just after the following rising edge, it pushes the expected triple. The monitor pops and compares that triple at the next falling edge, exactly one cycle after the stimulus. Hold cycles are scheduled the same way, so a hold that is wrongly followed shows up in that same sample window.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD      = 2'd0,
    ACT_FAULT     = 2'd1,
    ACT_STEP_UOP  = 2'd2,
    ACT_NEXT_INSN = 2'd3
  } seq_act_e;
endpackage

// File: rtl/pcseq_decide.sv
module pcseq_decide
  import pcseq_pkg::*;
(
  input  logic     adv,
  input  logic     fault,
  input  logic     in_macro,
  input  logic     is_macro,
  input  logic     last_uop,
  output seq_act_e act
);
  logic busy_macro;

  always_comb begin
    busy_macro = in_macro | is_macro;
    if (!adv)                       act = ACT_HOLD;
    else if (fault)                 act = ACT_FAULT;
    else if (busy_macro && !last_uop) act = ACT_STEP_UOP;
    else                            act = ACT_NEXT_INSN;
  end
endmodule

// File: rtl/pcseq_upc.sv
module pcseq_upc
  import pcseq_pkg::*;
#(
  parameter int UW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_act_e      act,
  input  logic          adv,
  input  logic          fault,
  input  logic          last_uop,
  output logic [UW-1:0] upc,
  output logic          in_macro
);
  localparam logic [UW-1:0] UONE = UW'(1);
  logic [UW-1:0] nupc;

  always_ff @(posedge clk) begin
    if (rst) begin
      upc      <= '0;
      nupc     <= UONE;
      in_macro <= 1'b0;
    end else begin
      case (act)
        ACT_FAULT, ACT_NEXT_INSN: begin
          upc      <= '0;
          nupc     <= UONE;
          in_macro <= 1'b0;
        end
        ACT_STEP_UOP: begin
          upc      <= nupc;
          nupc     <= nupc + UONE;
          in_macro <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_UPC_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_macro |-> upc == '0) else $error("upc nonzero outside macro"); // R6
  AST_UPC_STEP: assert property (@(posedge clk) disable iff (rst)
    in_macro && adv && !fault && !last_uop |=> upc == $past(upc) + UONE)
    else $error("upc did not step"); // R5
  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    adv && fault |=> !in_macro && upc == '0) else $error("fault kept macro"); // R9
endmodule

// File: rtl/pcseq_pc_chain.sv
module pcseq_pc_chain
  import pcseq_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          INSN_BYTES = 4,
  parameter bit          DELAY_SLOT = 1'b1,
  parameter logic [31:0] RESET_VEC  = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_act_e      act,
  input  logic          adv,
  input  logic          fault,
  input  logic          in_macro,
  input  logic          last_uop,
  input  logic [AW-1:0] fault_vec,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] STEP  = AW'(INSN_BYTES);
  localparam logic [AW-1:0] RVEC  = AW'(RESET_VEC);

  logic [AW-1:0] npc;

  generate
    if (DELAY_SLOT) begin : g_dslot
      logic [AW-1:0] nnpc;
      always_ff @(posedge clk) begin
        if (rst) begin
          pc   <= RVEC;
          npc  <= RVEC + STEP;
          nnpc <= RVEC + STEP + STEP;
        end else begin
          case (act)
            ACT_FAULT: begin
              pc   <= fault_vec;
              npc  <= fault_vec + STEP;
              nnpc <= fault_vec + STEP + STEP;
            end
            ACT_NEXT_INSN: begin
              pc   <= npc;
              npc  <= nnpc;
              nnpc <= nnpc + STEP;
            end
            default: ;
          endcase
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) begin
          pc  <= RVEC;
          npc <= RVEC + STEP;
        end else begin
          case (act)
            ACT_FAULT: begin
              pc  <= fault_vec;
              npc <= fault_vec + STEP;
            end
            ACT_NEXT_INSN: begin
              pc  <= npc;
              npc <= npc + STEP;
            end
            default: ;
          endcase
        end
      end
    end
  endgenerate

  AST_PC_HOLD_MACRO: assert property (@(posedge clk) disable iff (rst)
    in_macro && adv && !fault && !last_uop |=> $stable(pc))
    else $error("pc moved mid macro"); // R5
  AST_FAULT_VEC: assert property (@(posedge clk) disable iff (rst)
    adv && fault |=> pc == $past(fault_vec)) else $error("fault vector missed"); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pc)) else $error("pc moved without advance"); // R2
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          UW         = 8,
  parameter int          INSN_BYTES = 4,
  parameter bit          DELAY_SLOT = 1'b1,
  parameter logic [31:0] RESET_VEC  = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic          is_macro_i,
  input  logic          last_uop_i,
  input  logic          fault_i,
  input  logic [AW-1:0] fault_vec_i,
  output logic [AW-1:0] pc_o,
  output logic [UW-1:0] upc_o,
  output logic          in_macro_o
);
  seq_act_e act;

  pcseq_decide u_decide (
    .adv      (adv_i),
    .fault    (fault_i),
    .in_macro (in_macro_o),
    .is_macro (is_macro_i),
    .last_uop (last_uop_i),
    .act      (act)
  );

  pcseq_upc #(.UW(UW)) u_upc (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .adv      (adv_i),
    .fault    (fault_i),
    .last_uop (last_uop_i),
    .upc      (upc_o),
    .in_macro (in_macro_o)
  );

  pcseq_pc_chain #(
    .AW(AW), .INSN_BYTES(INSN_BYTES), .DELAY_SLOT(DELAY_SLOT), .RESET_VEC(RESET_VEC)
  ) u_chain (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .adv       (adv_i),
    .fault     (fault_i),
    .in_macro  (in_macro_o),
    .last_uop  (last_uop_i),
    .fault_vec (fault_vec_i),
    .pc        (pc_o)
  );

  AST_ENTRY_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    adv_i && !fault_i && !in_macro_o && is_macro_i && !last_uop_i |=>
      in_macro_o && $stable(pc_o)) else $error("macro entry wrong"); // R4
  AST_RETIRE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    adv_i && !fault_i && in_macro_o && last_uop_i |=>
      !in_macro_o && pc_o != $past(pc_o)) else $error("retire did not advance"); // R6
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
  localparam int AW = 32;
  localparam int UW = 8;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0, ism = 1'b0, lst = 1'b0, flt = 1'b0;
  logic [AW-1:0] fvec = '0;
  logic [AW-1:0] pc;
  logic [UW-1:0] upc;
  logic mac;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst(rst), .adv_i(adv), .is_macro_i(ism), .last_uop_i(lst),
    .fault_i(flt), .fault_vec_i(fvec), .pc_o(pc), .upc_o(upc), .in_macro_o(mac)
  );

  typedef struct {
    logic [AW-1:0] pc;
    logic [UW-1:0] upc;
    logic          mac;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  logic [AW-1:0] m_pc;
  logic [UW-1:0] m_upc;
  logic          m_mac;

  task automatic step(input logic a, input logic im, input logic l,
                      input logic f, input logic [AW-1:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    adv = a; ism = im; lst = l; flt = f; fvec = v;
    if (a) begin
      if (f) begin
        m_pc = v; m_upc = '0; m_mac = 1'b0;
      end else if ((m_mac || im) && !l) begin
        m_upc = m_upc + 1'b1; m_mac = 1'b1;
      end else begin
        m_pc = m_pc + 32'd4; m_upc = '0; m_mac = 1'b0;
      end
    end
    e.pc = m_pc; e.upc = m_upc; e.mac = m_mac; e.tag = tag;
    @(posedge clk);
    #1;
    sbq.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        checks++;
        if (pc !== e.pc || upc !== e.upc || mac !== e.mac) begin
          errors++;
          $display("FAIL %s: got pc=%h upc=%0d mac=%b, expected pc=%h upc=%0d mac=%b",
                   e.tag, pc, upc, mac, e.pc, e.upc, e.mac);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pc = RV; m_upc = '0; m_mac = 1'b0;
    checks++;
    if (pc !== RV || upc !== '0 || mac !== 1'b0) begin
      errors++;
      $display("FAIL R1: got pc=%h upc=%0d mac=%b, expected pc=%h upc=0 mac=0", pc, upc, mac, RV);
    end
    step(0, 1, 1, 1, 32'hDEAD_0000, "R2 idle garbage");
    step(1, 0, 0, 0, '0, "R3 plain");
    step(1, 0, 0, 0, '0, "R3 plain");
    step(1, 0, 1, 0, '0, "R8 last ignored");
    step(1, 1, 0, 0, '0, "R4 enter macro");
    step(1, 1, 0, 0, '0, "R5 step ismacro ignored");
    step(0, 0, 1, 0, '0, "R2 hold in macro");
    step(1, 0, 0, 0, '0, "R5 step");
    step(1, 0, 1, 0, '0, "R6 last uop");
    step(1, 0, 0, 0, '0, "R3 plain after macro");
    step(1, 1, 1, 0, '0, "R7 single uop");
    step(1, 1, 0, 0, '0, "R4 enter again");
    step(1, 0, 0, 1, 32'h0000_8000, "R9 fault mid macro");
    step(1, 0, 0, 0, '0, "R10 seq after fault");
    step(1, 0, 0, 0, '0, "R10 seq after fault");
    step(1, 1, 1, 1, 32'h0000_0200, "R9 fault priority");
    step(1, 0, 1, 0, '0, "R8 R10 after fault");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule